// File: doc/BRIEF.md
# Debug Communications Channel Mailbox

This block is a two-ended data mailbox that links an external debug port to a processor-side register interface. It holds two words. The receive word is written by the debugger and read by the core. The transmit word is written by the core and read by the debugger. A ready flag marks each word as full or empty. Sticky flags record a debugger write into a full receive word (overrun) and a debugger read of an empty transmit word (underrun). A cumulative error flag gathers both.

Both ends run on one clock and are applied in a fixed order inside each cycle. The core access goes first. The debugger's overrun or underrun check then sees the flags as the core access left them. A combined core access reads the receive word and writes the transmit word, with a single flag update. Level interrupt requests tell the core that data is waiting or that there is space to send. A packed status word gives every flag.

Top module: `dcc_mailbox`

## Requirements
- R1: After reset every flag is 0 and both words are 0. So status is 0, irq_rx is 0, irq_tx is 1 and irq_comm is 1.
- R2: A debugger write while receive-full is set (after the same-cycle core access) is an overrun. It sets the sticky overrun flag (status bit 2) and leaves the receive word and receive-full unchanged.
- R3: A debugger read while transmit-full is clear (after the same-cycle core access) is an underrun. It sets the sticky underrun flag (status bit 3) and leaves transmit-full clear.
- R4: A debugger write that does not overrun stores its word and sets receive-full (status bit 0). A debugger read that does not underrun returns the transmit word and clears transmit-full (status bit 1).
- R5: A core read returns the held receive word in the request cycle and clears receive-full at the clock edge that ends that cycle.
- R6: A core write stores its word and sets transmit-full at the same edge. The core side makes no full check, so a core write into a full transmit word overwrites it.
- R7: A combined core access returns the receive word and stores the transmit word. At one edge it clears receive-full and sets transmit-full.
- R8: When both ends access in the same cycle, the core access is applied first. A debugger write after a core read does not overrun. A debugger read after a core write does not underrun and returns the word the core is writing.
- R9: A clear-sticky command clears the overrun and underrun flags. It clears the error flag (status bit 4) only while halted is high. An overrun or underrun in the same cycle still sets its flags.
- R10: Any overrun or underrun sets the error flag. The error flag stays set until a clear-sticky command is given while halted.
- R11: The status bits, from bit 0 upward, are receive-full, transmit-full, overrun, underrun and error. irq_rx equals receive-full, irq_tx equals not transmit-full, and irq_comm is their OR. All of them show the result of an access from the clock edge that applies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halted | input | 1 | Core is halted; lets clear-sticky clear the error flag |
| dbg_rx_wr | input | 1 | Debugger write of the receive word |
| dbg_rx_wdata | input | DATA_W | Debugger write data |
| dbg_tx_rd | input | 1 | Debugger read of the transmit word |
| dbg_tx_rdata | output | DATA_W | Transmit word seen by the debugger (includes a same-cycle core write) |
| dbg_clr_sticky | input | 1 | Clear-sticky-errors command |
| core_rx_rd | input | 1 | Core read of the receive word |
| core_tx_wr | input | 1 | Core write of the transmit word |
| core_dbl | input | 1 | Combined core read of receive and write of transmit |
| core_tx_wdata | input | DATA_W | Core write data (plain or combined) |
| core_rx_rdata | output | DATA_W | Receive word seen by the core |
| status | output | 5 | Packed flags as listed in R11 |
| irq_rx | output | 1 | Data waiting for the core |
| irq_tx | output | 1 | Transmit word free for the core |
| irq_comm | output | 1 | Either request active |

## Verification
A wrong flag shows up on the status word and on the interrupt requests one clock edge after the access that corrupted it. From then on it changes the outcome of the next overrun or underrun check. A wrong word shows up on the read data of the next read from the matching side. The bench keeps a behavioural model of the flags and words, updated core-first. It compares status, interrupts and read data every cycle, so a divergence is reported in the cycle it first becomes visible. Directed sequences cover same-cycle collisions, combined access and clear while halted or running; a long random phase follows them.

// File: rtl/dcc_mbx_pkg.sv
package dcc_mbx_pkg;

  // Packed flag set; field order fixes the status bit positions (rx_full is bit 0).
  typedef struct packed {
    logic err;
    logic tx_und;
    logic rx_ovr;
    logic tx_full;
    logic rx_full;
  } dcc_flags_t;

  localparam int unsigned STAT_W = $bits(dcc_flags_t);

endpackage

// File: rtl/dcc_mbx_flags.sv
module dcc_mbx_flags
  import dcc_mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halted,
  input  logic       core_rd,
  input  logic       core_wr,
  input  logic       dbg_wr,
  input  logic       dbg_rd,
  input  logic       clr,
  output logic       rx_take,
  output dcc_flags_t flags_q
);

  dcc_flags_t flags_d;
  logic       rxf_mid;
  logic       txf_mid;
  logic       ovr;
  logic       und;
  logic       tx_give;
  logic       upd_en;

  // Core access first, then the debugger's check against the updated flags.
  always_comb begin
    rxf_mid = flags_q.rx_full & ~core_rd;
    txf_mid = flags_q.tx_full | core_wr;
    ovr     = dbg_wr & rxf_mid;
    rx_take = dbg_wr & ~rxf_mid;
    und     = dbg_rd & ~txf_mid;
    tx_give = dbg_rd & txf_mid;

    flags_d.rx_full = rxf_mid | rx_take;
    flags_d.tx_full = txf_mid & ~tx_give;
    flags_d.rx_ovr  = (flags_q.rx_ovr & ~clr) | ovr;
    flags_d.tx_und  = (flags_q.tx_und & ~clr) | und;
    flags_d.err     = (flags_q.err & ~(clr & halted)) | ovr | und;

    upd_en = core_rd | core_wr | dbg_wr | dbg_rd | clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (upd_en) begin
      flags_q <= flags_d;
    end
  end

  // R2: overrun records the sticky flag and keeps receive-full set
  a_r2_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_wr && flags_q.rx_full && !core_rd) |=> (flags_q.rx_ovr && flags_q.rx_full));

  // R3: underrun records the sticky flag and leaves transmit-full clear
  a_r3_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_rd && !flags_q.tx_full && !core_wr) |=> (flags_q.tx_und && !flags_q.tx_full));

  // R5: core read empties the receive side when no debugger write refills it
  a_r5_core_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd && !dbg_wr) |=> !flags_q.rx_full);

  // R6: core write fills the transmit side when no debugger read drains it
  a_r6_core_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr && !dbg_rd) |=> flags_q.tx_full);

  // R10: error flag survives anything but a clear while halted
  a_r10_err_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.err && !(clr && halted)) |=> flags_q.err);

  // R10: a sticky overrun or underrun always has the error flag with it
  always_comb begin
    if (rst_n) begin
      a_r10_err_covers: assert (!(flags_q.rx_ovr || flags_q.tx_und) || flags_q.err);
    end
  end

endmodule

// File: rtl/dcc_mbx_data.sv
module dcc_mbx_data #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_load,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic [DATA_W-1:0] rx_word,
  output logic [DATA_W-1:0] tx_word
);

  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (rx_load) begin
      rx_q <= rx_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (tx_load) begin
      tx_q <= tx_wdata;
    end
  end

  // Core side is ordered first, so a same-cycle debugger read sees the new word.
  always_comb begin
    rx_word = rx_q;
    tx_word = tx_load ? tx_wdata : tx_q;
  end

  // R6: a core write lands in the transmit word at the edge
  a_r6_tx_stored: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (tx_q == $past(tx_wdata)));

endmodule

// File: rtl/dcc_mbx_irq.sv
module dcc_mbx_irq #(
  parameter bit REG_OUT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_full,
  input  logic tx_full,
  output logic irq_rx,
  output logic irq_tx,
  output logic irq_comm
);

  logic rx_req;
  logic tx_req;

  always_comb begin
    rx_req = rx_full;
    tx_req = ~tx_full;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic rx_q;
      logic tx_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rx_q <= 1'b0;
          tx_q <= 1'b1;
        end else begin
          rx_q <= rx_req;
          tx_q <= tx_req;
        end
      end
      always_comb begin
        irq_rx   = rx_q;
        irq_tx   = tx_q;
        irq_comm = rx_q | tx_q;
      end
    end else begin : g_comb
      always_comb begin
        irq_rx   = rx_req;
        irq_tx   = tx_req;
        irq_comm = rx_req | tx_req;
      end
    end
  endgenerate

endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox
  import dcc_mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halted,
  input  logic              dbg_rx_wr,
  input  logic [DATA_W-1:0] dbg_rx_wdata,
  input  logic              dbg_tx_rd,
  output logic [DATA_W-1:0] dbg_tx_rdata,
  input  logic              dbg_clr_sticky,
  input  logic              core_rx_rd,
  input  logic              core_tx_wr,
  input  logic              core_dbl,
  input  logic [DATA_W-1:0] core_tx_wdata,
  output logic [DATA_W-1:0] core_rx_rdata,
  output logic [STAT_W-1:0] status,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_comm
);

  logic       core_rd_any;
  logic       core_wr_any;
  logic       rx_take;
  dcc_flags_t flags_q;

  always_comb begin
    core_rd_any = core_rx_rd | core_dbl;
    core_wr_any = core_tx_wr | core_dbl;
  end

  dcc_mbx_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .halted  (halted),
    .core_rd (core_rd_any),
    .core_wr (core_wr_any),
    .dbg_wr  (dbg_rx_wr),
    .dbg_rd  (dbg_tx_rd),
    .clr     (dbg_clr_sticky),
    .rx_take (rx_take),
    .flags_q (flags_q)
  );

  dcc_mbx_data #(.DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_load  (rx_take),
    .rx_wdata (dbg_rx_wdata),
    .tx_load  (core_wr_any),
    .tx_wdata (core_tx_wdata),
    .rx_word  (core_rx_rdata),
    .tx_word  (dbg_tx_rdata)
  );

  dcc_mbx_irq #(.REG_OUT(1'b0)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_full  (flags_q.rx_full),
    .tx_full  (flags_q.tx_full),
    .irq_rx   (irq_rx),
    .irq_tx   (irq_tx),
    .irq_comm (irq_comm)
  );

  always_comb status = flags_q;

  // R2: overrunning write leaves the core-visible word untouched
  a_r2_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_rx_wr && status[0] && !core_rd_any) |=> $stable(core_rx_rdata));

  // R7: combined access empties receive and fills transmit at one edge
  a_r7_dbl_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (core_dbl && !dbg_rx_wr && !dbg_tx_rd) |=> (!status[0] && status[1]));

  // R8: debugger write right behind a core read in the same cycle never overruns
  a_r8_order_no_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd_any && dbg_rx_wr && !status[2] && !dbg_clr_sticky) |=> (!status[2] && status[0]));

  // R11: data-waiting request follows receive-full
  a_r11_irq_rx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> irq_rx);

endmodule

// File: tb/dcc_mailbox_tb_top.sv
module dcc_mailbox_tb_top;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         halted = 1'b0;
  logic         dbg_rx_wr = 1'b0;
  logic [W-1:0] dbg_rx_wdata = '0;
  logic         dbg_tx_rd = 1'b0;
  logic [W-1:0] dbg_tx_rdata;
  logic         dbg_clr_sticky = 1'b0;
  logic         core_rx_rd = 1'b0;
  logic         core_tx_wr = 1'b0;
  logic         core_dbl = 1'b0;
  logic [W-1:0] core_tx_wdata = '0;
  logic [W-1:0] core_rx_rdata;
  logic [4:0]   status;
  logic         irq_rx, irq_tx, irq_comm;

  int errors = 0;
  int checks = 0;

  // behavioural model state
  bit           m_rxf, m_txf, m_ovr, m_und, m_err;
  logic [W-1:0] m_rxw, m_txw;

  always #4 clk = ~clk;

  dcc_mailbox #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .halted(halted),
    .dbg_rx_wr(dbg_rx_wr), .dbg_rx_wdata(dbg_rx_wdata),
    .dbg_tx_rd(dbg_tx_rd), .dbg_tx_rdata(dbg_tx_rdata),
    .dbg_clr_sticky(dbg_clr_sticky),
    .core_rx_rd(core_rx_rd), .core_tx_wr(core_tx_wr), .core_dbl(core_dbl),
    .core_tx_wdata(core_tx_wdata), .core_rx_rdata(core_rx_rdata),
    .status(status), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_comm(irq_comm)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] m_status();
    return {m_err, m_und, m_ovr, m_txf, m_rxf};
  endfunction

  task automatic check_state(input string tag);
    logic [4:0] e;
    e = m_status();
    check(status === e, {tag, " R11 status"}, W'(status), W'(e));
    check(irq_rx === m_rxf && irq_tx === !m_txf && irq_comm === (m_rxf | !m_txf),
          {tag, " R11 irq"}, W'({irq_rx, irq_tx, irq_comm}), W'({m_rxf, !m_txf, m_rxf | !m_txf}));
  endtask

  // One cycle of stimulus; called just after a falling edge.
  task automatic step(input bit crd, input bit cwr, input bit cdbl, input bit dwr, input bit drd,
                      input bit clr, input bit hlt, input logic [W-1:0] cdata,
                      input logic [W-1:0] ddata, input string tag);
    logic [W-1:0] exp_core, exp_dbg;
    bit rd, wr, dbg_ok;
    core_rx_rd = crd; core_tx_wr = cwr; core_dbl = cdbl; core_tx_wdata = cdata;
    dbg_rx_wr = dwr; dbg_tx_rd = drd; dbg_rx_wdata = ddata;
    dbg_clr_sticky = clr; halted = hlt;
    rd = crd | cdbl;
    wr = cwr | cdbl;
    exp_core = m_rxw;
    exp_dbg  = wr ? cdata : m_txw;
    dbg_ok   = drd && (m_txf || wr);
    #1;
    if (rd) check(core_rx_rdata === exp_core, {tag, " R5 core read data"}, core_rx_rdata, exp_core);
    if (dbg_ok) check(dbg_tx_rdata === exp_dbg, {tag, " R4 debugger read data"}, dbg_tx_rdata, exp_dbg);
    @(posedge clk);
    // core first
    if (rd) m_rxf = 1'b0;
    if (wr) begin m_txf = 1'b1; m_txw = cdata; end
    if (clr) begin m_ovr = 1'b0; m_und = 1'b0; if (hlt) m_err = 1'b0; end
    if (dwr) begin
      if (m_rxf) begin m_ovr = 1'b1; m_err = 1'b1; end
      else begin m_rxf = 1'b1; m_rxw = ddata; end
    end
    if (drd) begin
      if (!m_txf) begin m_und = 1'b1; m_err = 1'b1; end
      else m_txf = 1'b0;
    end
    @(negedge clk);
    check_state(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, '0, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_rxf = 0; m_txf = 0; m_ovr = 0; m_und = 0; m_err = 0; m_rxw = '0; m_txw = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(status === 5'd0, "R1 status at reset", W'(status), '0);
    check(irq_rx === 1'b0 && irq_tx === 1'b1 && irq_comm === 1'b1, "R1 irq at reset",
          W'({irq_rx, irq_tx, irq_comm}), W'(3'b011));
    check(core_rx_rdata === '0 && dbg_tx_rdata === '0, "R1 words at reset", core_rx_rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);
    idle("R1 idle");

    // R4 debugger write fills, R5 core read drains
    step(0, 0, 0, 1, 0, 0, 0, '0, 32'hA5A5_0001, "R4 dbg write");
    check(status[0] === 1'b1, "R4 rx full set", W'(status[0]), 1);
    // R2 overrun keeps word
    step(0, 0, 0, 1, 0, 0, 0, '0, 32'hDEAD_BEEF, "R2 overrun");
    check(status[2] === 1'b1 && core_rx_rdata === 32'hA5A5_0001, "R2 overrun flag and word",
          core_rx_rdata, 32'hA5A5_0001);
    check(status[4] === 1'b1, "R10 error on overrun", W'(status[4]), 1);
    step(1, 0, 0, 0, 0, 0, 0, '0, '0, "R5 core read");
    // R3 underrun
    step(0, 0, 0, 0, 1, 0, 0, '0, '0, "R3 underrun");
    check(status[3] === 1'b1 && status[1] === 1'b0, "R3 underrun flag", W'(status), 5'b11100);
    // R9 clear while running keeps error
    step(0, 0, 0, 0, 0, 1, 0, '0, '0, "R9 clear running");
    check(status[4] === 1'b1 && status[3:2] === 2'b00, "R9 err kept running", W'(status), 5'b10000);
    step(0, 0, 0, 0, 0, 1, 1, '0, '0, "R9 clear halted");
    check(status === 5'd0, "R9 err cleared halted", W'(status), '0);
    // R6 core write then overwrite, then debugger read
    step(0, 1, 0, 0, 0, 0, 0, 32'h1111_2222, '0, "R6 core write");
    step(0, 1, 0, 0, 0, 0, 0, 32'h3333_4444, '0, "R6 core overwrite");
    step(0, 0, 0, 0, 1, 0, 0, '0, '0, "R4 dbg read");
    check(status[1] === 1'b0, "R4 tx full cleared", W'(status[1]), 0);
    // R7 combined access
    step(0, 0, 0, 1, 0, 0, 0, '0, 32'h7777_0007, "R7 prep");
    step(0, 0, 1, 0, 0, 0, 0, 32'h8888_0008, '0, "R7 combined");
    check(status[1:0] === 2'b10, "R7 flags after combined", W'(status[1:0]), 2);
    step(0, 0, 0, 0, 1, 0, 0, '0, '0, "R7 dbg reads combined word");
    // R8 same-cycle ordering
    step(0, 0, 0, 1, 0, 0, 0, '0, 32'h0000_00AA, "R8 prep");
    step(1, 1, 0, 1, 1, 0, 0, 32'h0000_0BBB, 32'h0000_0CCC, "R8 collide");
    check(status[3:2] === 2'b00 && status[0] === 1'b1 && status[1] === 1'b0,
          "R8 no overrun or underrun", W'(status), 5'b00001);
    // R9 clear with simultaneous overrun still sets
    step(0, 0, 0, 1, 0, 1, 1, '0, 32'h0000_0DDD, "R9 clear plus overrun");
    check(status[2] === 1'b1 && status[4] === 1'b1, "R9 new error wins", W'(status), 5'b10101);
    step(0, 0, 0, 0, 0, 1, 1, '0, '0, "R9 cleanup");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] r;
      r = 10'($urandom);
      step(r[0], r[1], r[2] & r[3], r[4], r[5], r[6] & r[7], r[8], $urandom, $urandom, "R10 random");
    end
    idle("R11 final");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule